// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Guard

This block watches the control pins that a DDR SDRAM controller drives toward the memory. On every clock edge it turns the two clock-enable samples (the previous and current cycle), chip select, RAS, CAS, WE, the auto-precharge address bit and the two bank-select bits into a single command. The command is presented as a one-hot vector, one clock after the pins. Power-down entry, self-refresh entry, clock-enable exit and held clock-enable are decoded alongside the ordinary commands.

Next to the decoder, four bank state machines follow what the command stream does to each bank. Each bank has three states. **Idle** means precharged; its timer counts down tRP. **Open** means a row is active. **Lockout** is the auto-precharge window; its timer counts down the read or write formula. The transitions are as follows:
- Idle→Open on an activate, but only once the timer is zero.
- Open→Idle on a single-bank precharge to that bank or on a precharge-all. The timer loads tRP−1.
- Open→Lockout on a read or write with auto-precharge.
- Lockout→Idle once the window has elapsed. The timer is then zero.

A command that breaks a timing or state rule raises a violation flag for one cycle, aligned with the decoded command, together with the offending bank number. A flagged command leaves every bank state unchanged. Burst length, tRP and write recovery (tDPL) are parameters.

Top module: `sdram_cmd_guard`

## Requirements
- R1: While reset is held, and in the first cycle after reset, the command output is NOP (bit 0), the violation flag is low and no bank reads open. After reset every bank is precharged with its timer at zero.
- R2: With both clock-enable samples high, the command is decoded from chip select, RAS, CAS and WE, and appears one cycle after the pins. The one-hot bit positions are: deselect (chip select high) bit 1; NOP (L,H,H,H) bit 0; burst stop (L,H,H,L) bit 11; auto refresh (L,L,L,H) bit 12.
- R3: The pattern L,L,L,L with both clock-enable samples high is a mode-register write. Bank bit 0 low gives the normal register (bit 2). Bank bit 0 high gives the extended register (bit 3).
- R4: The following patterns, all with chip select low, are decoded:
  - Activate (RAS L, CAS H, WE H) is bit 4.
  - Read (H,L,H) is bit 5, or bit 6 when the auto-precharge bit is high.
  - Write (H,L,L) is bit 7, or bit 8 when the auto-precharge bit is high.
  
  A legal activate marks the addressed bank open.
- R5: The pattern L,H,L is a precharge. With the auto-precharge bit low it is single-bank (bit 9) and closes only the addressed bank. With it high it is precharge-all (bit 10): every bank closes and the bank bits are ignored.
- R6: Clock-enable going high→low is decoded as follows:
  - With the auto-refresh pattern it is self-refresh entry (bit 13).
  - Otherwise, if no bank is open or locked, it is precharge power-down (bit 14).
  - Otherwise it is active power-down (bit 15).
  
  Clock-enable going low→high is exit (bit 16). Clock-enable low in both samples is hold (bit 17).
- R7: A read or write, with or without auto-precharge, to a bank that is not open raises the violation flag with that bank number. The bank state is unchanged.
- R8: An activate to a bank that is open, locked, or fewer than tRP cycles after its precharge is flagged and changes nothing. An activate exactly tRP cycles after the precharge is legal.
- R9: A read with auto-precharge at cycle n locks the bank until n+BL/2+tRP. Any read, write, activate or single precharge to the bank before then is flagged. An activate at exactly that cycle is legal.
- R10: A write with auto-precharge at cycle n locks the bank until n+BL/2+1+tDPL+tRP, with the same flagging as R9.
- R11: A mode-register write is flagged (bank field zero) unless every bank is precharged and at least tRP cycles have passed since the last precharge.
- R12: The violation flag is high only in the cycle of the offending command. It is low on the following legal command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_prev | input | 1 | Clock-enable sampled in the previous cycle |
| cke_cur | input | 1 | Clock-enable sampled in this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ap_bit | input | 1 | Auto-precharge / precharge-all address bit |
| ba | input | BA_W | Bank select |
| cmd_onehot | output | NCMD (18) | Decoded command, one-hot, registered |
| viol | output | 1 | Rule violation for the command now shown |
| viol_bank | output | BA_W | Bank of the violation (zero for mode-register writes) |
| bank_open | output | 2**BA_W | Per-bank open flag |

## Verification
The hardest situation to reach is a command that lands on the last cycle of an auto-precharge lockout, followed by one that lands on the first cycle after it. The write window in particular spans several parameters. The bench reaches it by issuing the auto-precharge command, padding with a counted run of NOPs, and then placing two activates back to back. The first activate must be flagged and the second must open the bank. The same one-cycle boundary is probed after a plain precharge, both for activate and for mode-register writes.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

    // Command codes; the numeric value is the bit position in the one-hot output.
    typedef enum logic [4:0] {
        CMD_NOP      = 5'd0,
        CMD_DESEL    = 5'd1,
        CMD_MRS      = 5'd2,
        CMD_EMRS     = 5'd3,
        CMD_ACT      = 5'd4,
        CMD_RD       = 5'd5,
        CMD_RDA      = 5'd6,
        CMD_WR       = 5'd7,
        CMD_WRA      = 5'd8,
        CMD_PRE      = 5'd9,
        CMD_PREA     = 5'd10,
        CMD_BST      = 5'd11,
        CMD_AREF     = 5'd12,
        CMD_SREF_IN  = 5'd13,
        CMD_PPD_IN   = 5'd14,
        CMD_APD_IN   = 5'd15,
        CMD_CKE_EXIT = 5'd16,
        CMD_CKE_HOLD = 5'd17
    } cmd_e;

    localparam int NCMD = 18;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_OPEN   = 2'd1,
        BK_APLOCK = 2'd2
    } bank_st_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_guard_pkg::*;
(
    input  logic cke_prev,
    input  logic cke_cur,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic ap_bit,
    input  logic ba_ext,
    input  logic any_active,
    output cmd_e cmd
);

    logic [2:0] rcw;
    assign rcw = {ras_n, cas_n, we_n};

    always_comb begin
        cmd = CMD_NOP;
        unique case ({cke_prev, cke_cur})
            2'b00: cmd = CMD_CKE_HOLD;
            2'b01: cmd = CMD_CKE_EXIT;
            2'b10: begin
                if (!cs_n && rcw == 3'b001)
                    cmd = CMD_SREF_IN;
                else if (any_active)
                    cmd = CMD_APD_IN;
                else
                    cmd = CMD_PPD_IN;
            end
            2'b11: begin
                if (cs_n) begin
                    cmd = CMD_DESEL;
                end else begin
                    unique case (rcw)
                        3'b111: cmd = CMD_NOP;
                        3'b011: cmd = CMD_ACT;
                        3'b101: cmd = ap_bit ? CMD_RDA : CMD_RD;
                        3'b100: cmd = ap_bit ? CMD_WRA : CMD_WR;
                        3'b010: cmd = ap_bit ? CMD_PREA : CMD_PRE;
                        3'b110: cmd = CMD_BST;
                        3'b001: cmd = CMD_AREF;
                        3'b000: cmd = ba_ext ? CMD_EMRS : CMD_MRS;
                        default: cmd = CMD_NOP;
                    endcase
                end
            end
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_guard_pkg::*;
#(
    parameter int TIMER_W = 4,
    parameter int PRE_WIN = 3,
    parameter int RD_WIN  = 5,
    parameter int WR_WIN  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic sel,
    output logic is_open,
    output logic is_locked,
    output logic is_ready
);

    // Counters load window-1 so that the bank is usable when the count reads zero.
    localparam logic [TIMER_W-1:0] PRE_LOAD = TIMER_W'(PRE_WIN - 1);
    localparam logic [TIMER_W-1:0] RD_LOAD  = TIMER_W'(RD_WIN - 1);
    localparam logic [TIMER_W-1:0] WR_LOAD  = TIMER_W'(WR_WIN - 1);
    localparam logic [TIMER_W-1:0] ONE      = TIMER_W'(1);

    bank_st_e          st_q, st_nx;
    logic [TIMER_W-1:0] tm_q, tm_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= BK_IDLE;
            tm_q <= '0;
        end else begin
            st_q <= st_nx;
            tm_q <= tm_nx;
        end
    end

    always_comb begin
        st_nx = st_q;
        tm_nx = tm_q;
        unique case (st_q)
            BK_IDLE: begin
                if (tm_q != '0)
                    tm_nx = tm_q - ONE;
                if (cmd == CMD_ACT && sel && tm_q == '0)
                    st_nx = BK_OPEN;
            end
            BK_OPEN: begin
                if ((cmd == CMD_PRE && sel) || cmd == CMD_PREA) begin
                    st_nx = BK_IDLE;
                    tm_nx = PRE_LOAD;
                end else if (cmd == CMD_RDA && sel) begin
                    st_nx = BK_APLOCK;
                    tm_nx = RD_LOAD;
                end else if (cmd == CMD_WRA && sel) begin
                    st_nx = BK_APLOCK;
                    tm_nx = WR_LOAD;
                end
            end
            BK_APLOCK: begin
                if (tm_q <= ONE) begin
                    st_nx = BK_IDLE;
                    tm_nx = '0;
                end else begin
                    tm_nx = tm_q - ONE;
                end
            end
            default: begin
                st_nx = BK_IDLE;
                tm_nx = '0;
            end
        endcase
    end

    always_comb begin
        is_open   = (st_q == BK_OPEN);
        is_locked = (st_q == BK_APLOCK);
        is_ready  = (st_q == BK_IDLE) && (tm_q == '0);
    end

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import sdram_guard_pkg::*;
#(
    parameter int BA_W = 2,
    parameter int BL   = 4,
    parameter int TRP  = 3,
    parameter int TDPL = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cke_prev,
    input  logic                  cke_cur,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic                  ap_bit,
    input  logic [BA_W-1:0]       ba,
    output logic [NCMD-1:0]       cmd_onehot,
    output logic                  viol,
    output logic [BA_W-1:0]       viol_bank,
    output logic [(2**BA_W)-1:0]  bank_open
);

    localparam int NBANK   = 2 ** BA_W;
    localparam int RD_WIN  = BL / 2 + TRP;
    localparam int WR_WIN  = BL / 2 + 1 + TDPL + TRP;
    localparam int TIMER_W = $clog2(WR_WIN + 1);

    cmd_e             cmd_now, cmd_q;
    logic [NBANK-1:0] sel, b_open, b_lock, b_ready;
    logic             any_active, viol_now, viol_q;
    logic [BA_W-1:0]  vbank_now, vbank_q;

    assign any_active = |(b_open | b_lock);

    sdram_cmd_decode u_dec (
        .cke_prev  (cke_prev),
        .cke_cur   (cke_cur),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ap_bit    (ap_bit),
        .ba_ext    (ba[0]),
        .any_active(any_active),
        .cmd       (cmd_now)
    );

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        assign sel[i] = (ba == BA_W'(i));
        sdram_bank_fsm #(
            .TIMER_W(TIMER_W),
            .PRE_WIN(TRP),
            .RD_WIN (RD_WIN),
            .WR_WIN (WR_WIN)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd_now),
            .sel      (sel[i]),
            .is_open  (b_open[i]),
            .is_locked(b_lock[i]),
            .is_ready (b_ready[i])
        );
    end

    // Rule check against the bank states before this edge updates them.
    always_comb begin
        viol_now  = 1'b0;
        vbank_now = ba;
        unique case (cmd_now)
            CMD_ACT:                       viol_now = !b_ready[ba];
            CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: viol_now = !b_open[ba];
            CMD_PRE:                       viol_now = b_lock[ba];
            CMD_MRS, CMD_EMRS: begin
                viol_now  = !(&b_ready);
                vbank_now = '0;
            end
            default:                       viol_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= CMD_NOP;
            viol_q  <= 1'b0;
            vbank_q <= '0;
        end else begin
            cmd_q   <= cmd_now;
            viol_q  <= viol_now;
            vbank_q <= viol_now ? vbank_now : '0;
        end
    end

    for (genvar k = 0; k < NCMD; k++) begin : g_oh
        assign cmd_onehot[k] = (cmd_q == cmd_e'(k));
    end

    assign viol      = viol_q;
    assign viol_bank = vbank_q;
    assign bank_open = b_open;

endmodule

// File: rtl/sdram_cmd_guard_chk.sv
module sdram_cmd_guard_chk
    import sdram_guard_pkg::*;
#(
    parameter int BA_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCMD-1:0]      cmd_onehot,
    input logic                 viol,
    input logic [BA_W-1:0]      viol_bank,
    input logic [(2**BA_W)-1:0] bank_open
);

    logic is_rw, is_guarded;
    assign is_rw = cmd_onehot[int'(CMD_RD)] | cmd_onehot[int'(CMD_RDA)]
                 | cmd_onehot[int'(CMD_WR)] | cmd_onehot[int'(CMD_WRA)];
    assign is_guarded = is_rw | cmd_onehot[int'(CMD_ACT)] | cmd_onehot[int'(CMD_PRE)]
                      | cmd_onehot[int'(CMD_MRS)] | cmd_onehot[int'(CMD_EMRS)];

    // R2
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_onehot) == 1);

    // R4
    rw_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_onehot[int'(CMD_RD)] | cmd_onehot[int'(CMD_WR)]) && !viol) |-> (bank_open != '0));

    // R5
    prea_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_onehot[int'(CMD_PREA)] |-> (bank_open == '0));

    // R6
    ppd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_onehot[int'(CMD_PPD_IN)] |-> (bank_open == '0));

    // R7
    rw_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rw && viol) |-> !bank_open[viol_bank]);

    // R11
    mrs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_onehot[int'(CMD_MRS)] | cmd_onehot[int'(CMD_EMRS)]) && !viol) |-> (bank_open == '0));

    // R12
    viol_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> is_guarded);

endmodule

bind sdram_cmd_guard sdram_cmd_guard_chk #(.BA_W(BA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_onehot(cmd_onehot),
    .viol      (viol),
    .viol_bank (viol_bank),
    .bank_open (bank_open)
);

// File: tb/test_sdram_cmd_guard.sv
module test_sdram_cmd_guard;
    import sdram_guard_pkg::*;

    localparam int CLK_P  = 10;
    localparam int BA_W   = 2;
    localparam int BL     = 4;
    localparam int TRP    = 3;
    localparam int TDPL   = 2;
    localparam int RD_WIN = BL / 2 + TRP;
    localparam int WR_WIN = BL / 2 + 1 + TDPL + TRP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke_prev = 1'b1, cke_cur = 1'b1;
    logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, ap_bit = 1'b0;
    logic [BA_W-1:0] ba = '0;
    logic [NCMD-1:0] cmd_onehot;
    logic viol;
    logic [BA_W-1:0] viol_bank;
    logic [3:0] bank_open;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    sdram_cmd_guard #(.BA_W(BA_W), .BL(BL), .TRP(TRP), .TDPL(TDPL)) i_sdram_cmd_guard (
        .clk(clk), .rst_n(rst_n), .cke_prev(cke_prev), .cke_cur(cke_cur),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ap_bit(ap_bit),
        .ba(ba), .cmd_onehot(cmd_onehot), .viol(viol), .viol_bank(viol_bank),
        .bank_open(bank_open)
    );

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare all outputs after the command just issued.
    task automatic expect_out(string req, cmd_e c, bit v, int vb, int opn);
        logic [NCMD-1:0] oh;
        oh = '0;
        oh[int'(c)] = 1'b1;
        check(req, "cmd_onehot", int'(cmd_onehot), int'(oh));
        check(req, "viol", int'(viol), int'(v));
        if (v) check(req, "viol_bank", int'(viol_bank), vb);
        check(req, "bank_open", int'(bank_open), opn);
    endtask

    // Drive one cycle of pins; returns after the edge that captures them.
    task automatic pins(bit cp, bit cc, bit cs, bit r, bit c, bit w, bit ap, int b);
        cke_prev = cp; cke_cur = cc; cs_n = cs; ras_n = r; cas_n = c; we_n = w;
        ap_bit = ap; ba = BA_W'(b);
        @(negedge clk);
    endtask

    task automatic nop();          pins(1,1,0,1,1,1,0,0); endtask
    task automatic act(int b);     pins(1,1,0,0,1,1,0,b); endtask
    task automatic rd(int b, bit ap); pins(1,1,0,1,0,1,ap,b); endtask
    task automatic wr(int b, bit ap); pins(1,1,0,1,0,0,ap,b); endtask
    task automatic pre(int b);     pins(1,1,0,0,1,0,0,b); endtask
    task automatic prea(int b);    pins(1,1,0,0,1,0,1,b); endtask
    task automatic mrs(int b);     pins(1,1,0,0,0,0,0,b); endtask
    task automatic settle();       repeat (TRP) nop(); endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        expect_out("R1", CMD_NOP, 0, 0, 0);
        rst_n = 1'b1;
        nop();
        expect_out("R1", CMD_NOP, 0, 0, 0);
    endtask

    task automatic t_basic();
        pins(1,1,1,0,0,0,0,0); expect_out("R2", CMD_DESEL, 0, 0, 0);
        nop();                 expect_out("R2", CMD_NOP,   0, 0, 0);
        pins(1,1,0,1,1,0,0,0); expect_out("R2", CMD_BST,   0, 0, 0);
        pins(1,1,0,0,0,1,0,0); expect_out("R2", CMD_AREF,  0, 0, 0);
    endtask

    task automatic t_mrs();
        mrs(0); expect_out("R3", CMD_MRS,  0, 0, 0);
        mrs(1); expect_out("R3", CMD_EMRS, 0, 0, 0);
    endtask

    task automatic t_act_rw();
        act(1);   expect_out("R4", CMD_ACT, 0, 0, 4'b0010);
        rd(1, 0); expect_out("R4", CMD_RD,  0, 0, 4'b0010);
        wr(1, 0); expect_out("R4", CMD_WR,  0, 0, 4'b0010);
        pre(1);   expect_out("R5", CMD_PRE, 0, 0, 4'b0000);
        settle();
    endtask

    task automatic t_pre();
        act(0);  expect_out("R4", CMD_ACT,  0, 0, 4'b0001);
        act(2);  expect_out("R4", CMD_ACT,  0, 0, 4'b0101);
        pre(0);  expect_out("R5", CMD_PRE,  0, 0, 4'b0100);
        act(3);  expect_out("R4", CMD_ACT,  0, 0, 4'b1100);
        prea(1); expect_out("R5", CMD_PREA, 0, 0, 4'b0000);
        settle();
    endtask

    task automatic t_cke();
        pins(1,0,0,1,1,1,0,0); expect_out("R6", CMD_PPD_IN,   0, 0, 4'b0000);
        pins(0,0,0,1,1,1,0,0); expect_out("R6", CMD_CKE_HOLD, 0, 0, 4'b0000);
        pins(0,1,0,1,1,1,0,0); expect_out("R6", CMD_CKE_EXIT, 0, 0, 4'b0000);
        act(0);                expect_out("R4", CMD_ACT,      0, 0, 4'b0001);
        pins(1,0,1,1,1,1,0,0); expect_out("R6", CMD_APD_IN,   0, 0, 4'b0001);
        pins(0,1,1,1,1,1,0,0); expect_out("R6", CMD_CKE_EXIT, 0, 0, 4'b0001);
        pre(0);                expect_out("R5", CMD_PRE,      0, 0, 4'b0000);
        settle();
        pins(1,0,0,0,0,1,0,0); expect_out("R6", CMD_SREF_IN,  0, 0, 4'b0000);
        pins(0,1,1,1,1,1,0,0); expect_out("R6", CMD_CKE_EXIT, 0, 0, 4'b0000);
        nop();
    endtask

    task automatic t_rw_closed();
        rd(2, 0); expect_out("R7", CMD_RD,  1, 2, 4'b0000);
        wr(3, 1); expect_out("R7", CMD_WRA, 1, 3, 4'b0000);
        nop();    expect_out("R12", CMD_NOP, 0, 0, 4'b0000);
    endtask

    task automatic t_act_guard();
        act(1); expect_out("R8", CMD_ACT, 0, 0, 4'b0010);
        act(1); expect_out("R8", CMD_ACT, 1, 1, 4'b0010);
        pre(1); expect_out("R8", CMD_PRE, 0, 0, 4'b0000);
        for (int k = 1; k < TRP; k++) begin
            act(1); expect_out("R8", CMD_ACT, 1, 1, 4'b0000);
        end
        act(1); expect_out("R8", CMD_ACT, 0, 0, 4'b0010);
        pre(1);
        settle();
    endtask

    task automatic t_rda();
        act(0);   expect_out("R9", CMD_ACT, 0, 0, 4'b0001);
        rd(0, 1); expect_out("R9", CMD_RDA, 0, 0, 4'b0000);
        rd(0, 0); expect_out("R9", CMD_RD,  1, 0, 4'b0000);
        for (int k = 2; k < RD_WIN - 1; k++) nop();
        act(0);   expect_out("R9", CMD_ACT, 1, 0, 4'b0000);
        act(0);   expect_out("R9", CMD_ACT, 0, 0, 4'b0001);
        pre(0);
        settle();
    endtask

    task automatic t_wra();
        act(2);   expect_out("R10", CMD_WRA == CMD_WRA ? CMD_ACT : CMD_ACT, 0, 0, 4'b0100);
        wr(2, 1); expect_out("R10", CMD_WRA, 0, 0, 4'b0000);
        pre(2);   expect_out("R10", CMD_PRE, 1, 2, 4'b0000);
        for (int k = 2; k < WR_WIN - 1; k++) nop();
        act(2);   expect_out("R10", CMD_ACT, 1, 2, 4'b0000);
        act(2);   expect_out("R10", CMD_ACT, 0, 0, 4'b0100);
        pre(2);
        settle();
    endtask

    task automatic t_mrs_guard();
        act(3); expect_out("R11", CMD_ACT, 0, 0, 4'b1000);
        mrs(0); expect_out("R11", CMD_MRS, 1, 0, 4'b1000);
        pre(3); expect_out("R11", CMD_PRE, 0, 0, 4'b0000);
        for (int k = 1; k < TRP; k++) begin
            mrs(0); expect_out("R11", CMD_MRS, 1, 0, 4'b0000);
        end
        mrs(1); expect_out("R11", CMD_EMRS, 0, 0, 4'b0000);
        nop();  expect_out("R12", CMD_NOP, 0, 0, 4'b0000);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_mrs();
        t_act_rw();
        t_pre();
        t_cke();
        t_rw_closed();
        t_act_guard();
        t_rda();
        t_wra();
        t_mrs_guard();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule